// File: doc/BRIEF.md
# Scanline-Matching Interrupt Generator

This block counts video scanlines while the picture is being drawn and raises an interrupt when the count reaches a line number that software has programmed. Each scanline is announced by a single-cycle tick from the video timing logic. A level input reports whether rendering is currently active. When a tick arrives while rendering is off, the count, the pending state and the in-frame flag all start again from zero. The tick that follows counts as line one.

Software uses two byte-wide write registers. One sets the target line. The other is an enable byte, and it arms the interrupt only when it holds exactly 0x80. A read strobe on the status register returns a pending bit and an in-frame bit, and the same read acknowledges the interrupt. The in-frame flag is also brought out as its own port for neighbouring logic.

Top module: `scanline_irq_gen`

## Requirements
- R1: A write with `cpu_addr` equal to TARGET_ADDR (default 0x5203) loads the target line from `cpu_wdata`. A write to ENABLE_ADDR (default 0x5204) loads the enable byte. A write to any other address changes neither register.
- R2: A tick while `render_active` is low clears the line count, the pending flag and `in_frame`. `irq` is low after that edge.
- R3: A tick while `render_active` is high adds one to the line count, modulo 2^LINE_W, and sets `in_frame`. If the new count equals the target line, the pending flag is set.
- R4: `irq` is high exactly when the pending flag is set and the enable byte is 0x80. Any other enable value, for example 0x81 or 0xC0, holds `irq` low.
- R5: `status` shows the pending flag in bit 7 and `in_frame` in bit 6. Bits 5 to 0 are always zero.
- R6: A cycle with `cpu_rd` high and no pending-setting tick clears the pending flag at its closing edge, so `irq` falls.
- R7: If a tick sets the pending flag in the same cycle as a read, the flag is set after the edge. The value seen on `status` during that read is the state from before the edge.
- R8: `irq` is a level, active high. Once high, it stays high until a read acknowledges it, a tick arrives with rendering inactive, or the enable byte is rewritten.
- R9: After reset the target, the enable byte, the line count, the pending flag and `in_frame` are all zero, so `status` and `irq` are zero.
- R10: With a target of 0, the pending flag is set on the 2^LINE_W-th active tick after a clear, when the count wraps to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_tick | input | 1 | One-cycle pulse per scanline |
| render_active | input | 1 | High while rendering is active |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | ADDR_W | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Status read strobe, which also acknowledges the interrupt |
| irq | output | 1 | Interrupt request, level, active high |
| status | output | 8 | Bit 7 is pending, bit 6 is in-frame, all other bits are zero |
| in_frame | output | 1 | In-frame flag for neighbouring logic |

## Verification
The assertions assume that `line_tick` and `cpu_rd` are synchronous strobes that are valid at the sampling edge. They also assume that the status value is taken during the strobe cycle, and that the target and enable bytes change only through `cpu_wr`. The bench drives every input half a period away from the rising edge and keeps each strobe high for exactly one cycle. Its random mix keeps targets small and holds rendering on through long stretches, so that matches, acknowledges, ties between a set and a read, and clears by an inactive tick all occur often. Directed sequences cover rejected enable values, writes to stray addresses and the wrap of the count at a target of zero.

// File: rtl/scan_irq_pkg.sv
package scan_irq_pkg;
   localparam int DATA_W    = 8;
   localparam int PEND_BIT  = 7;
   localparam int FRAME_BIT = 6;
   typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
   import scan_irq_pkg::*;
#(
   parameter int              ADDR_W      = 16,
   parameter int              LINE_W      = 8,
   parameter logic [ADDR_W-1:0] TARGET_ADDR = 16'h5203,
   parameter logic [ADDR_W-1:0] ENABLE_ADDR = 16'h5204,
   parameter byte_t           ARM_KEY     = 8'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  byte_t             wdata,
   output logic [LINE_W-1:0] target,
   output logic              armed
);
   byte_t enable_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         target   <= '0;
         enable_q <= '0;
      end else if (wr) begin
         if (addr == TARGET_ADDR) target   <= wdata[LINE_W-1:0];
         if (addr == ENABLE_ADDR) enable_q <= wdata;
      end
   end

   assign armed = (enable_q == ARM_KEY);
endmodule

// File: rtl/scan_line_counter.sv
module scan_line_counter #(
   parameter int LINE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              render,
   input  logic [LINE_W-1:0] target,
   output logic [LINE_W-1:0] count,
   output logic              frame,
   output logic              hit,
   output logic              wipe
);
   localparam logic [LINE_W-1:0] STEP = LINE_W'(1);
   logic [LINE_W-1:0] count_nx;

   assign count_nx = count + STEP;
   assign wipe     = tick & ~render;
   assign hit      = tick & render & (count_nx == target);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         frame <= 1'b0;
      end else if (wipe) begin
         count <= '0;
         frame <= 1'b0;
      end else if (tick) begin
         count <= count_nx;
         frame <= 1'b1;
      end
   end
endmodule

// File: rtl/irq_pend_flag.sv
module irq_pend_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic wipe,
   input  logic ack,
   output logic pending
);
   always_ff @(posedge clk) begin
      if (!rst_n)     pending <= 1'b0;
      else if (wipe)  pending <= 1'b0;
      else if (hit)   pending <= 1'b1;
      else if (ack)   pending <= 1'b0;
   end
endmodule

// File: rtl/scanline_irq_gen.sv
module scanline_irq_gen
   import scan_irq_pkg::*;
#(
   parameter int                ADDR_W      = 16,
   parameter int                LINE_W      = 8,
   parameter logic [ADDR_W-1:0] TARGET_ADDR = 16'h5203,
   parameter logic [ADDR_W-1:0] ENABLE_ADDR = 16'h5204
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_tick,
   input  logic              render_active,
   input  logic              cpu_wr,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [7:0]        cpu_wdata,
   input  logic              cpu_rd,
   output logic              irq,
   output logic [7:0]        status,
   output logic              in_frame
);
   if (LINE_W < 1 || LINE_W > DATA_W) begin : g_bad_line_w
      $error("LINE_W must lie between 1 and the data width");
   end
   if (TARGET_ADDR == ENABLE_ADDR) begin : g_bad_addr
      $error("target and enable addresses must differ");
   end

   logic [LINE_W-1:0] tgt_line;
   logic [LINE_W-1:0] line_cnt;
   logic              armed;
   logic              hit;
   logic              wipe;
   logic              pending;

   irq_cfg_regs #(
      .ADDR_W(ADDR_W), .LINE_W(LINE_W),
      .TARGET_ADDR(TARGET_ADDR), .ENABLE_ADDR(ENABLE_ADDR), .ARM_KEY(8'h80)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(cpu_wr), .addr(cpu_addr),
      .wdata(cpu_wdata), .target(tgt_line), .armed(armed)
   );

   scan_line_counter #(.LINE_W(LINE_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(line_tick), .render(render_active),
      .target(tgt_line), .count(line_cnt), .frame(in_frame),
      .hit(hit), .wipe(wipe)
   );

   irq_pend_flag u_pend (
      .clk(clk), .rst_n(rst_n), .hit(hit), .wipe(wipe),
      .ack(cpu_rd), .pending(pending)
   );

   assign irq = pending & armed;

   always_comb begin
      status            = '0;
      status[PEND_BIT]  = pending;
      status[FRAME_BIT] = in_frame;
   end
endmodule

// File: rtl/scan_irq_chk.sv
module scan_irq_chk #(
   parameter int LINE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              line_tick,
   input logic              render_active,
   input logic              cpu_wr,
   input logic              cpu_rd,
   input logic              irq,
   input logic [7:0]        status,
   input logic              in_frame,
   input logic [LINE_W-1:0] count,
   input logic [LINE_W-1:0] target
);
   assert_inactive_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (line_tick && !render_active) |=> (!irq && status == 8'h00 && count == '0));

   assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (line_tick && render_active) |=> (count == LINE_W'($past(count) + 1'b1) && in_frame));

   assert_irq_needs_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> status[7]);

   assert_status_layout_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (status[5:0] == 6'd0 && status[6] == in_frame));

   assert_read_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && !line_tick) |=> !status[7] && !irq);

   assert_set_beats_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && line_tick && render_active && LINE_W'(count + 1'b1) == target) |=> status[7]);

   assert_irq_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !cpu_rd && !cpu_wr && !(line_tick && !render_active)) |=> irq);
endmodule

bind scanline_irq_gen scan_irq_chk #(.LINE_W(LINE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .render_active(render_active),
   .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .irq(irq), .status(status),
   .in_frame(in_frame), .count(line_cnt), .target(tgt_line)
);

// File: tb/sim_scanline_irq_gen.sv
module sim_scanline_irq_gen;
   localparam int          CLK_PERIOD = 10;
   localparam logic [15:0] A_TGT = 16'h5203;
   localparam logic [15:0] A_EN  = 16'h5204;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        line_tick = 1'b0, render_active = 1'b0, cpu_wr = 1'b0, cpu_rd = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        irq, in_frame;
   logic [7:0]  status;

   int total = 0, bad = 0;
   logic [7:0] m_cnt = '0, m_tgt = '0, m_en = '0;
   logic       m_pend = 1'b0, m_frame = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   scanline_irq_gen u0 (
      .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .render_active(render_active),
      .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd),
      .irq(irq), .status(status), .in_frame(in_frame)
   );

   function automatic logic exp_irq();
      return m_pend && (m_en == 8'h80);
   endfunction

   function automatic logic [7:0] exp_status();
      return {m_pend, m_frame, 6'd0};
   endfunction

   task automatic cmp(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_edge(input logic t, input logic r, input logic w,
                             input logic [15:0] a, input logic [7:0] d, input logic rd);
      if (t && !r) begin
         m_cnt = '0; m_pend = 1'b0; m_frame = 1'b0;
      end else if (t) begin
         m_cnt   = m_cnt + 8'd1;
         m_frame = 1'b1;
         if (m_cnt == m_tgt) m_pend = 1'b1;
         else if (rd)        m_pend = 1'b0;
      end else if (rd) begin
         m_pend = 1'b0;
      end
      if (w && a == A_TGT) m_tgt = d;
      if (w && a == A_EN)  m_en  = d;
   endtask

   // called at a falling edge; takes one clock
   task automatic step(input logic t, input logic r, input logic w,
                       input logic [15:0] a, input logic [7:0] d, input logic rd);
      line_tick = t; render_active = r; cpu_wr = w; cpu_addr = a;
      cpu_wdata = d; cpu_rd = rd;
      #1;
      if (rd) cmp("R7 read value before edge", status, exp_status());
      @(posedge clk);
      model_edge(t, r, w, a, d, rd);
      @(negedge clk);
      line_tick = 1'b0; cpu_wr = 1'b0; cpu_rd = 1'b0;
      cmp("R4 irq", {7'd0, irq}, {7'd0, exp_irq()});
      cmp("R5 status", status, exp_status());
      cmp("R3 in_frame", {7'd0, in_frame}, {7'd0, m_frame});
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 190000);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      cmp("R9 reset status", status, 8'h00);
      cmp("R9 reset irq", {7'd0, irq}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 configuration, R3 match on third line
      step(0, 0, 1, A_TGT, 8'd3, 0);
      step(0, 0, 1, A_EN, 8'h80, 0);
      step(1, 0, 0, 0, 0, 0);
      step(1, 1, 0, 0, 0, 0);
      step(1, 1, 0, 0, 0, 0);
      cmp("R3 no match on line 2", {7'd0, irq}, 8'h00);
      step(1, 1, 0, 0, 0, 0);
      cmp("R3 match on line 3", {7'd0, irq}, 8'h01);
      // R8 level held across idle cycles and non-matching ticks
      step(0, 1, 0, 0, 0, 0);
      step(1, 1, 0, 0, 0, 0);
      cmp("R8 irq held", {7'd0, irq}, 8'h01);
      // R6 read acknowledges
      step(0, 1, 0, 0, 0, 1);
      cmp("R6 ack clears irq", {7'd0, irq}, 8'h00);
      cmp("R6 ack clears pending", status, 8'h40);
      // R4 rejected enable value
      step(0, 1, 1, A_EN, 8'h81, 0);
      step(1, 0, 0, 0, 0, 0);
      for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 0, 0);
      cmp("R4 enable 0x81 keeps irq low", {7'd0, irq}, 8'h00);
      cmp("R4 pending still visible", status, 8'hC0);
      // R1 stray address ignored
      step(0, 1, 1, 16'h5205, 8'h80, 0);
      cmp("R1 stray write ignored", {7'd0, irq}, 8'h00);
      step(0, 1, 1, A_EN, 8'h80, 0);
      cmp("R1 enable write arms", {7'd0, irq}, 8'h01);
      // R2 inactive tick clears
      step(1, 0, 0, 0, 0, 0);
      cmp("R2 inactive tick clears", status, 8'h00);
      // R7 set beats read
      step(1, 1, 0, 0, 0, 0);
      step(1, 1, 0, 0, 0, 0);
      step(1, 1, 0, 0, 0, 1);
      cmp("R7 set wins over read", {7'd0, irq}, 8'h01);
      // R10 wrap with target 0
      step(0, 1, 1, A_TGT, 8'd0, 0);
      step(1, 0, 0, 0, 0, 0);
      for (int i = 0; i < 255; i++) step(1, 1, 0, 0, 0, 0);
      cmp("R10 no match before wrap", {7'd0, irq}, 8'h00);
      step(1, 1, 0, 0, 0, 0);
      cmp("R10 match at wrap", {7'd0, irq}, 8'h01);

      // random mix
      begin
         logic r;
         r = 1'b1;
         for (int i = 0; i < 4000; i++) begin
            logic t, w, rd;
            logic [15:0] a;
            logic [7:0]  d;
            int sel;
            if ($urandom_range(0, 63) == 0) r = ~r;
            t   = ($urandom_range(0, 3) == 0);
            rd  = ($urandom_range(0, 7) == 0);
            w   = ($urandom_range(0, 9) == 0);
            sel = $urandom_range(0, 2);
            a   = (sel == 0) ? A_TGT : (sel == 1) ? A_EN : 16'(16'h5200 + $urandom_range(0, 15));
            if (a == A_TGT) d = 8'($urandom_range(0, 12));
            else begin
               sel = $urandom_range(0, 3);
               d = (sel == 1) ? 8'h00 : (sel == 2) ? 8'($urandom_range(0, 255)) : 8'h80;
            end
            step(t, r, w, a, d, rd);
         end
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule